// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Serial Readout

This block is the digital half of a 12-bit successive-approximation converter. A host selects it with an active-low chip select and supplies a serial clock. The block closes the sample switch, runs a binary search against an external comparator through a trial code that drives the converter's DAC, and puts each result bit on the serial data line as soon as that bit is decided.

A transaction produces a low null bit, then the word MSB first. If the host keeps clocking, the word follows again LSB first, with the shared LSB sent only once, and after that the line carries zeros. Once the MSB-first word is complete, the block raises a power-down flag for the analog bias and comparator, and the serial clock goes on shifting out the stored data. Raising chip select at any time ends the transaction and releases the data line.

The serial clock and chip select are sampled in the block's own system clock. Both pass through a synchronizer of `SYNC_STAGES` flops, and edges are detected after it. Every serial event therefore takes effect a fixed few system cycles after the pin edge. Both serial clock idle levels work, because the block ignores any falling edge that comes before the first rising edge of a transaction.

Top module: `sar_serial_ctrl`

## Requirements
- R1: After reset with chip select already low, no serial clock activity starts a transaction: `sdo_oe` and `sample_en` stay 0 until chip select has gone high and then low again.
- R2: `sample_en` rises on the first serial clock rising edge after chip select falls, stays 1 across that clock's falling edge and the second rising edge, and returns to 0 on the second falling edge. This holds whether the clock idles low or high.
- R3: On the falling edge that ends sampling, `sdo_oe` becomes 1 and `sdo` drives a 0 null bit.
- R4: The next 12 falling edges put out result bits B11 down to B0. Each trial code keeps all decided bits and sets the bit under test to 1. `cmp_above` = 1 means the input is at or above the trial code, and that bit is then kept; otherwise it is cleared.
- R5: With chip select still low, the 11 falling edges after B0 put out B1, B2, and so on up to B11. B0 is not sent a second time.
- R6: Every falling edge after B11 of the LSB-first word puts out 0 while chip select stays low.
- R7: `sdo` changes only in response to a serial clock falling edge. `sdo_oe` is 0 whenever chip select is high, and at most `SYNC_STAGES`+2 system clocks pass before this takes effect.
- R8: The result is straight binary. An input at or below zero gives 000h, and an input at or above 4095 gives FFFh.
- R9: `pwr_dn` is 1 in idle. It is 0 from the start of sampling until the falling edge that sends B0, and 1 again from that edge onward.
- R10: Chip select going high mid-transaction clears `sdo_oe` and `sample_en`, sets `pwr_dn` and returns the block to idle. The next transaction then runs normally. If the rise of chip select and a serial clock fall reach the block together, the rise of chip select wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| cmp_above | input | 1 | Comparator decision: 1 when the held input is at or above the trial code |
| trial_code | output | WIDTH | Trial code driving the DAC |
| sample_en | output | 1 | Sample switch closed when 1 |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for the serial data line (0 = high impedance) |
| pwr_dn | output | 1 | Power-down request for the bias and comparator |

## Verification
Two functions can land in the same system cycle: a chip select rise that aborts the transaction, and a serial clock fall that would make a decision or shift a bit. The bench provokes this by changing chip select and the serial clock in the same cycle, at clock numbers drawn at random during sampling, during the search and during the replay. It then judges that the line is released, the switch is open and power-down is set. It also checks that the following transaction returns the exact converted code, which shows the abort left no stale search state behind.

// File: rtl/sar_serial_pkg.sv
package sar_serial_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_SAMPLE,
      ST_CONV,
      ST_REPLAY,
      ST_ZEROS
   } seq_state_t;
endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign lvl = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= {STAGES{RST_VAL}};
            end else begin
               chain_q[0] <= d;
               for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
         end
         assign lvl = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg #(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             start,
   input  logic             decide,
   input  logic             above,
   output logic [WIDTH-1:0] trial,
   output logic             last
);
   localparam int PW = $clog2(WIDTH);

   logic [WIDTH-1:0] trial_q;
   logic [PW-1:0]    ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trial_q <= '0;
         ptr_q   <= '0;
      end else if (clear) begin
         trial_q <= '0;
         ptr_q   <= '0;
      end else if (start) begin
         trial_q <= {1'b1, {(WIDTH-1){1'b0}}};
         ptr_q   <= PW'(WIDTH-1);
      end else if (decide) begin
         trial_q[ptr_q] <= above;
         if (ptr_q != '0) begin
            trial_q[ptr_q - PW'(1)] <= 1'b1;
            ptr_q                   <= ptr_q - PW'(1);
         end
      end
   end

   assign trial = trial_q;
   assign last  = (ptr_q == '0);
endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
   import sar_serial_pkg::*;
#(
   parameter int WIDTH       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sclk,
   input  logic             cmp_above,
   output logic [WIDTH-1:0] trial_code,
   output logic             sample_en,
   output logic             sdo,
   output logic             sdo_oe,
   output logic             pwr_dn
);
   localparam int IW = $clog2(WIDTH);

   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("sar_serial_ctrl: WIDTH must lie in 2..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("sar_serial_ctrl: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic cs_hi, cs_rise, cs_fall;
   logic sclk_lvl, sclk_rise, sclk_fall;
   logic unused_edges;

   // Chip select history resets to "low" so a select held low at power-up never looks like a fall.
   sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .d(cs_n),
      .lvl(cs_hi), .rise(cs_rise), .fall(cs_fall)
   );

   sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
      .clk(clk), .rst_n(rst_n), .d(sclk),
      .lvl(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall)
   );

   assign unused_edges = &{1'b0, cs_rise, sclk_lvl};

   seq_state_t    state_q;
   logic          fcnt_q;
   logic [IW-1:0] idx_q;
   logic          sdo_q, oe_q;
   logic          sar_start, sar_decide, sar_last;

   assign sar_start  = !cs_hi && (state_q == ST_SAMPLE) && sclk_fall && fcnt_q;
   assign sar_decide = !cs_hi && (state_q == ST_CONV) && sclk_fall;

   sar_search_reg #(.WIDTH(WIDTH)) u_search (
      .clk(clk), .rst_n(rst_n),
      .clear(cs_hi), .start(sar_start), .decide(sar_decide),
      .above(cmp_above), .trial(trial_code), .last(sar_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fcnt_q  <= 1'b0;
         idx_q   <= '0;
         sdo_q   <= 1'b0;
         oe_q    <= 1'b0;
      end else if (cs_hi) begin
         state_q <= ST_IDLE;
         fcnt_q  <= 1'b0;
         idx_q   <= '0;
         sdo_q   <= 1'b0;
         oe_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (cs_fall) state_q <= ST_ARM;
            ST_ARM: if (sclk_rise) begin
               state_q <= ST_SAMPLE;
               fcnt_q  <= 1'b0;
            end
            ST_SAMPLE: if (sclk_fall) begin
               if (!fcnt_q) begin
                  fcnt_q <= 1'b1;
               end else begin
                  state_q <= ST_CONV;
                  oe_q    <= 1'b1;
                  sdo_q   <= 1'b0;
               end
            end
            ST_CONV: if (sclk_fall) begin
               sdo_q <= cmp_above;
               if (sar_last) begin
                  state_q <= ST_REPLAY;
                  idx_q   <= IW'(1);
               end
            end
            ST_REPLAY: if (sclk_fall) begin
               sdo_q <= trial_code[idx_q];
               if (idx_q == IW'(WIDTH-1)) state_q <= ST_ZEROS;
               else                       idx_q   <= idx_q + IW'(1);
            end
            ST_ZEROS: if (sclk_fall) sdo_q <= 1'b0;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sample_en = (state_q == ST_SAMPLE);
   assign pwr_dn    = (state_q == ST_IDLE) || (state_q == ST_REPLAY) || (state_q == ST_ZEROS);
   assign sdo       = sdo_q;
   assign sdo_oe    = oe_q;
endmodule

// File: rtl/sar_serial_ctrl_chk.sv
module sar_serial_ctrl_chk #(
   parameter int WIDTH = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_hi,
   input logic             sclk_rise,
   input logic             sclk_fall,
   input logic [WIDTH-1:0] trial_code,
   input logic             sample_en,
   input logic             sdo,
   input logic             sdo_oe,
   input logic             pwr_dn
);
   a_r7_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && $past(sdo_oe) && !$past(sclk_fall)) |-> $stable(sdo))
      else $error("a_r7_sdo_moves_on_fall");

   a_r7_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> (!sdo_oe && !sample_en))
      else $error("a_r7_quiet_when_deselected");

   a_r3_enable_with_null: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> ($past(sclk_fall) && !sdo))
      else $error("a_r3_enable_with_null");

   a_r2_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sample_en) |-> $past(sclk_rise))
      else $error("a_r2_sample_on_rise");

   a_r9_awake_while_sampling: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |-> (!pwr_dn && !sdo_oe))
      else $error("a_r9_awake_while_sampling");

   a_r4_trial_steps_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_fall && !cs_hi) |=> $stable(trial_code))
      else $error("a_r4_trial_steps_on_fall");
endmodule

bind sar_serial_ctrl sar_serial_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi),
   .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
   .trial_code(trial_code), .sample_en(sample_en),
   .sdo(sdo), .sdo_oe(sdo_oe), .pwr_dn(pwr_dn)
);

// File: tb/sar_serial_ctrl_bench.sv
module sar_serial_ctrl_bench;
   localparam int CLK_P = 10;
   localparam int HALF  = 10;
   localparam int NCLK  = 30;
   localparam int WD    = 150000;

   logic        clk = 1'b0;
   logic        rst_n, cs_n, sclk;
   int          vin;
   logic        cmp_above;
   logic [11:0] trial_code;
   logic        sample_en, sdo, sdo_oe, pwr_dn;

   int nchk = 0;
   int nerr = 0;

   always #(CLK_P/2) clk = ~clk;

   // behavioural comparator and DAC: input at or above the trial level
   assign cmp_above = (vin >= $signed({1'b0, trial_code}));

   sar_serial_ctrl u_sar_serial_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
      .cmp_above(cmp_above), .trial_code(trial_code),
      .sample_en(sample_en), .sdo(sdo), .sdo_oe(sdo_oe), .pwr_dn(pwr_dn)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic int exp_code(input int v);
      if (v <= 0)    return 0;
      if (v >= 4095) return 4095;
      return v;
   endfunction

   task automatic xfer(input int v, input bit idle_hi, input int abort_clk);
      logic oe_at [1:NCLK];
      logic sd_at [1:NCLK];
      logic pd_at [1:NCLK];
      logic en_hi [1:NCLK];
      logic en_lo [1:NCLK];
      logic s_mid;
      int   code, msbw, lsbw;
      bit   stable_ok, oe_ok, zero_ok;
      code      = exp_code(v);
      vin       = v;
      sclk      = idle_hi;
      stable_ok = 1;
      tick(4);
      chk(pwr_dn === 1'b1, "R9 idle power-down", int'(pwr_dn), 1);
      cs_n = 1'b0;
      tick(6);
      for (int k = 1; k <= NCLK; k++) begin
         if (k == abort_clk) begin
            // R10: chip select rise in the same cycle as a clock fall
            sclk = 1'b0;
            cs_n = 1'b1;
            tick(6);
            chk(sdo_oe === 1'b0 && sample_en === 1'b0 && pwr_dn === 1'b1,
                "R10 abort releases", {sdo_oe, sample_en, pwr_dn}, 3'b001);
            tick(10);
            return;
         end
         sclk = 1'b0;
         tick(HALF/2);
         s_mid    = sdo;
         en_lo[k] = sample_en;
         tick(HALF/2);
         oe_at[k] = sdo_oe;
         sd_at[k] = sdo;
         pd_at[k] = pwr_dn;
         if (k >= 2 && sdo_oe && s_mid !== sdo) stable_ok = 0;
         sclk = 1'b1;
         tick(HALF/2);
         en_hi[k] = sample_en;
         tick(HALF/2);
      end
      sclk = 1'b0;
      tick(HALF);
      sclk = idle_hi;
      tick(2);
      cs_n = 1'b1;
      tick(5);
      chk(sdo_oe === 1'b0, "R7 released after deselect", int'(sdo_oe), 0);
      chk(stable_ok, "R7 data steady within low phase", int'(stable_ok), 1);
      chk(en_lo[1] === 1'b0 && en_hi[1] === 1'b1 && en_lo[2] === 1'b1 &&
          en_hi[2] === 1'b1 && en_lo[3] === 1'b0, "R2 sample window",
          {en_lo[1], en_hi[1], en_lo[2], en_hi[2], en_lo[3]}, 5'b01110);
      oe_ok = (oe_at[1] === 1'b0) && (oe_at[2] === 1'b0);
      for (int k = 3; k <= NCLK; k++) if (oe_at[k] !== 1'b1) oe_ok = 0;
      chk(oe_ok, "R3 output enable window", int'(oe_ok), 1);
      chk(sd_at[3] === 1'b0, "R3 null bit", int'(sd_at[3]), 0);
      msbw = 0;
      for (int k = 4; k <= 15; k++) msbw = (msbw << 1) | int'(sd_at[k]);
      if (v <= 0 || v >= 4095) chk(msbw == code, "R8 saturated code", msbw, code);
      else                     chk(msbw == code, "R4 MSB-first word", msbw, code);
      lsbw = 0;
      for (int i = 1; i <= 11; i++) lsbw = lsbw | (int'(sd_at[15+i]) << i);
      chk(lsbw == (code & 32'hFFE), "R5 LSB-first replay", lsbw, code & 32'hFFE);
      zero_ok = 1;
      for (int k = 27; k <= NCLK; k++) if (sd_at[k] !== 1'b0) zero_ok = 0;
      chk(zero_ok, "R6 trailing zeros", int'(zero_ok), 1);
      chk(pd_at[3] === 1'b0 && pd_at[14] === 1'b0 && pd_at[15] === 1'b1,
          "R9 power-down after B0", {pd_at[3], pd_at[14], pd_at[15]}, 3'b001);
      tick(6);
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=%0d expected=finish", WD);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      bit seen;
      void'($urandom(32'd7741));
      rst_n = 1'b0;
      cs_n  = 1'b0;
      sclk  = 1'b0;
      vin   = 0;
      tick(5);
      rst_n = 1'b1;
      tick(3);
      chk(sdo_oe === 1'b0 && sample_en === 1'b0 && pwr_dn === 1'b1 && trial_code === 12'h000,
          "R9 reset state", {sdo_oe, sample_en, pwr_dn}, 3'b001);
      // R1: select low from power-up, clocks must not start anything
      seen = 0;
      for (int k = 0; k < 20; k++) begin
         sclk = ~sclk;
         tick(HALF);
         if (sdo_oe !== 1'b0 || sample_en !== 1'b0) seen = 1;
      end
      chk(!seen, "R1 no transaction without select edge", int'(seen), 0);
      sclk = 1'b0;
      cs_n = 1'b1;
      tick(10);

      xfer(0, 0, 0);
      xfer(4095, 0, 0);
      xfer(5000, 0, 0);
      xfer(-7, 0, 0);
      xfer(1, 0, 0);
      xfer(2048, 0, 0);
      xfer(2047, 0, 0);
      xfer(12'hAAA, 0, 0);
      xfer(1234, 1, 0);
      xfer(777, 0, 2);
      xfer(3000, 0, 3);
      xfer(3001, 0, 9);
      xfer(555, 0, 20);
      xfer(2900, 0, 0);
      for (int n = 0; n < 40; n++) begin
         int v, ab;
         v  = int'($urandom_range(4300)) - 100;
         ab = ($urandom_range(5) == 0) ? int'($urandom_range(25, 2)) : 0;
         xfer(v, bit'($urandom_range(1)), ab);
      end

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule